// File: doc/BRIEF.md
# Burst-Limited Receive Port Arbiter

This block decides which of several receive ports owns a shared packet system interface. Only one port is granted at a time. While a port holds the grant, the block counts the bus transfers the interface accepts from it. Once a configurable cap is reached, the block hands the interface to another port. The cap is set in units of four-byte groups, so the number of bus transfers it allows grows as the bus gets narrower. The cap applies only when the interface runs in packet-level-3 mode. In every other mode a burst ends only on an end of packet or when the port drops its ready flag.

When the cap runs out and no other port is ready, the current port keeps the grant if its buffer is above the almost-empty level or holds an end of packet. In that case the count restarts and no handover takes place. When a burst ends, the block pulses a burst-complete output for one cycle. It spends that cycle idle and re-arbitrates. The next winner is found in round-robin order, starting at the port after the one just served.

The mode, width and limit inputs are captured only when a burst starts or restarts, so changing them in the middle of a burst cannot disturb a count already under way.

Top module: `rx_burst_arbiter`

## Requirements
- R1: While reset is held low, and in the first cycle after it, `grant_valid` and `burst_end` are 0.
- R2: A grant goes only to a port whose ready flag was high in the preceding cycle. The winner is the first ready port found by scanning upward with wrap-around from the port after the last one served. After reset the scan starts at port 0.
- R3: In packet-level-3 mode (`pl3_mode`=1) with a limit L other than 0, a burst ends after exactly C accepted transfers, provided another port is ready. C is L+1 for `bus_width`=2 (32-bit), 2(L+1) for `bus_width`=1 (16-bit) and 4(L+1) for `bus_width`=0 (8-bit).
- R4: With `bus_width`=2 and L=1, the cap is 3 transfers, the same as for L=2.
- R5: A limit of 0 removes the cap. The burst continues for any number of transfers.
- R6: When `pl3_mode`=0, the limit is ignored and the burst continues for any number of transfers.
- R7: If the cap is reached while no other port is ready, the current port keeps the grant only when its above-almost-empty flag or its end-of-packet-pending flag is 1. The count then restarts at zero. Otherwise the burst ends.
- R8: A transfer with `xfer_eop`=1 ends the burst. The granted port's ready flag being low also ends the burst. This holds even when the same transfer reaches the cap.
- R9: In the cycle after a burst ends, `burst_end` is 1 for exactly that one cycle, `grant_valid` is 0, and the next grant can appear one cycle later.
- R10: `pl3_mode`, `bus_width` and `burst_limit` are captured only when a burst starts or restarts. Changes during a burst do not alter its cap.
- R11: `xfer` pulses while no port is granted have no effect on the count of the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_ready | input | NPORTS | Port has data to send |
| port_above_ae | input | NPORTS | Port fill is above its almost-empty level |
| port_eop_pend | input | NPORTS | Port holds an end of packet |
| bus_width | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit |
| pl3_mode | input | 1 | 1: packet-level-3 mode, the cap is active |
| burst_limit | input | LIMIT_W | Burst limit in four-byte groups, minus one |
| xfer | input | 1 | Interface accepted one bus transfer this cycle |
| xfer_eop | input | 1 | The accepted transfer carries end of packet |
| grant_port | output | PORT_W | Index of the granted port |
| grant_valid | output | 1 | A port is granted |
| burst_end | output | 1 | One-cycle pulse after a burst ends |

## Verification
Two of the block's functions can meet on the same transfer: the cap running out and an end of packet arriving. The bench provokes this by lining up an end-of-packet transfer exactly on the last counted transfer of a capped burst. At that moment only one port is ready and its almost-empty flag is set, so the cap alone would let it keep the grant. The bench then expects the burst to end, with a single `burst_end` pulse and a fresh grant one cycle later. The cap itself is swept over every bus width and several limits, and the transfer count is compared with the arithmetic formula.

// File: rtl/rxarb_pkg.sv
// Package: shared types for the receive port arbiter.
// Assumes bus width codes 0/1/2 mean 8/16/32-bit; code 3 behaves as 32-bit.
package rxarb_pkg;
    typedef enum logic [1:0] {
        BW_8  = 2'd0,
        BW_16 = 2'd1,
        BW_32 = 2'd2
    } bus_width_e;
endpackage

// File: rtl/burst_cap_calc.sv
// Module: burst_cap_calc
// Converts the limit field into a count of bus transfers for the current
// width, and says whether the cap is active at all.
// Assumes CNT_W >= LIMIT_W + 3 so four times (limit+1) fits.
module burst_cap_calc
    import rxarb_pkg::*;
#(
    parameter int LIMIT_W = 6,
    parameter int CNT_W   = LIMIT_W + 3
) (
    input  logic [1:0]         width,
    input  logic               pl3,
    input  logic [LIMIT_W-1:0] limit,
    output logic               cap_en,
    output logic [CNT_W-1:0]   cap
);
    localparam logic [LIMIT_W-1:0] LIM_ONE = LIMIT_W'(1);
    localparam logic [LIMIT_W-1:0] LIM_TWO = LIMIT_W'(2);

    bus_width_e         bw;
    logic [LIMIT_W-1:0] lim_eff;
    logic [CNT_W-1:0]   groups;

    assign bw = bus_width_e'(width);

    // Purpose: map the limit to transfers, honouring the 32-bit floor of two.
    always_comb begin
        lim_eff = limit;
        if (bw != BW_8 && bw != BW_16 && limit == LIM_ONE) begin
            lim_eff = LIM_TWO;
        end
        groups = CNT_W'(lim_eff) + CNT_W'(1);
        case (bw)
            BW_8:    cap = groups << 2;
            BW_16:   cap = groups << 1;
            default: cap = groups;
        endcase
        cap_en = pl3 && (limit != '0);
    end
endmodule

// File: rtl/rr_picker.sv
// Module: rr_picker
// Combinational round-robin search: finds the first requesting port at or
// after index 'start', wrapping around. Assumes start < N.
module rr_picker #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] pick
);
    // Purpose: scan N positions from start and keep the first hit.
    always_comb begin
        int idx;
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(start) + k) % N;
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/rx_burst_arbiter.sv
// Module: rx_burst_arbiter (top)
// Grants one receive port at a time to the shared interface and ends the
// grant on end of packet, on loss of ready, or when the burst cap runs out
// while another port waits. After each end it idles one cycle, pulses
// burst_end, and re-arbitrates round-robin from the port after the last.
// Assumes xfer is only meaningful while grant_valid is high.
module rx_burst_arbiter
    import rxarb_pkg::*;
#(
    parameter int NPORTS  = 4,
    parameter int LIMIT_W = 6,
    localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPORTS-1:0]  port_ready,
    input  logic [NPORTS-1:0]  port_above_ae,
    input  logic [NPORTS-1:0]  port_eop_pend,
    input  logic [1:0]         bus_width,
    input  logic               pl3_mode,
    input  logic [LIMIT_W-1:0] burst_limit,
    input  logic               xfer,
    input  logic               xfer_eop,
    output logic [PORT_W-1:0]  grant_port,
    output logic               grant_valid,
    output logic               burst_end
);
    localparam int CNT_W = LIMIT_W + 3;

    logic               active_q;
    logic [PORT_W-1:0]  cur_q;
    logic [PORT_W-1:0]  ptr_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cap_q;
    logic               cap_en_q;
    logic               done_q;

    logic               cap_en_w;
    logic [CNT_W-1:0]   cap_w;
    logic               pick_ok;
    logic [PORT_W-1:0]  pick_idx;
    logic [NPORTS-1:0]  cur_mask;
    logic               other_ready;
    logic               cur_ready;
    logic               cur_can_stay;
    logic               take;
    logic [CNT_W-1:0]   cnt_nxt;
    logic               at_cap;
    logic               end_burst;
    logic               renew;

    burst_cap_calc #(.LIMIT_W(LIMIT_W), .CNT_W(CNT_W)) u_cap (
        .width  (bus_width),
        .pl3    (pl3_mode),
        .limit  (burst_limit),
        .cap_en (cap_en_w),
        .cap    (cap_w)
    );

    rr_picker #(.N(NPORTS), .IW(PORT_W)) u_pick (
        .req   (port_ready),
        .start (ptr_q),
        .found (pick_ok),
        .pick  (pick_idx)
    );

    // Purpose: decide whether the granted burst ends, restarts or continues.
    always_comb begin
        cur_mask     = {{(NPORTS-1){1'b0}}, 1'b1} << cur_q;
        other_ready  = |(port_ready & ~cur_mask);
        cur_ready    = |(port_ready & cur_mask);
        cur_can_stay = !other_ready && |((port_above_ae | port_eop_pend) & cur_mask);
        take         = active_q && xfer;
        cnt_nxt      = cnt_q + CNT_W'(1);
        at_cap       = take && cap_en_q && (cnt_nxt == cap_q);
        end_burst    = active_q && (!cur_ready || (take && xfer_eop) ||
                                    (at_cap && !cur_can_stay));
        renew        = active_q && !end_burst && at_cap;
    end

    // Purpose: grant, count and release state with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cur_q    <= '0;
            ptr_q    <= '0;
            cnt_q    <= '0;
            cap_q    <= '0;
            cap_en_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= end_burst;
            if (!active_q) begin
                if (pick_ok) begin
                    active_q <= 1'b1;
                    cur_q    <= pick_idx;
                    cnt_q    <= '0;
                    cap_q    <= cap_w;
                    cap_en_q <= cap_en_w;
                end
            end else if (end_burst) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
                ptr_q    <= (cur_q == PORT_W'(NPORTS-1)) ? '0 : cur_q + PORT_W'(1);
            end else if (renew) begin
                cnt_q    <= '0;
                cap_q    <= cap_w;
                cap_en_q <= cap_en_w;
            end else if (take) begin
                cnt_q <= cnt_nxt;
            end
        end
    end

    assign grant_port  = cur_q;
    assign grant_valid = active_q;
    assign burst_end   = done_q;

    // R2: a fresh grant goes to a port that was ready
    p_pick_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !$past(active_q)) |-> (($past(port_ready) & cur_mask) != '0));

    // R3: count never reaches the cap while the cap is active
    p_cnt_below_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && cap_en_q) |-> (cnt_q < cap_q));

    // R4: an active cap is never below three transfers
    p_cap_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && cap_en_q) |-> (cap_q >= CNT_W'(3)));

    // R8: end-of-packet transfer releases the grant
    p_eop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && xfer && xfer_eop) |=> !grant_valid);

    // R8: losing ready releases the grant
    p_drop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !cur_ready) |=> (!grant_valid && burst_end));

    // R9: the end pulse lasts one cycle and falls in an idle cycle
    p_end_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end |-> (!grant_valid && !$past(burst_end)));

    // R10: the captured cap stays put once counting has begun
    p_cap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && $past(active_q) && cnt_q != '0) |-> ($stable(cap_q) && $stable(cap_en_q)));

    // R11: no count is kept while idle
    p_idle_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> (cnt_q == '0));
endmodule

// File: tb/rx_burst_arbiter_bench.sv
`timescale 1ns/1ps
module rx_burst_arbiter_bench;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [N-1:0] rdy = '0, ae = '0, ep = '0;
    logic [1:0] bw = 2'd2;
    logic       pl3 = 1'b1;
    logic [5:0] lim = 6'd0;
    logic       xfer = 1'b0, xeop = 1'b0;
    logic [1:0] gport;
    logic       gvalid, bend;

    int checks = 0, fails = 0;
    int last = N - 1;

    always #2 clk = ~clk;

    rx_burst_arbiter u_rx_burst_arbiter (
        .clk(clk), .rst_n(rst_n), .port_ready(rdy), .port_above_ae(ae),
        .port_eop_pend(ep), .bus_width(bw), .pl3_mode(pl3), .burst_limit(lim),
        .xfer(xfer), .xfer_eop(xeop), .grant_port(gport),
        .grant_valid(gvalid), .burst_end(bend)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic nclk();
        @(negedge clk);
    endtask

    task automatic wait_grant();
        for (int i = 0; i < 8 && !gvalid; i++) nclk();
    endtask

    function automatic int next_rr(input int from, input logic [N-1:0] r);
        for (int k = 1; k <= N; k++) begin
            if (r[(from + k) % N]) return (from + k) % N;
        end
        return -1;
    endfunction

    function automatic int exp_cap(input int w, input int l);
        if (w == 2) return (l == 1) ? 3 : l + 1;
        if (w == 1) return 2 * (l + 1);
        return 4 * (l + 1);
    endfunction

    // Drive transfers while granted; n = transfers accepted before release.
    task automatic run_burst(output int n, input int guard);
        n = 0;
        while (gvalid && n < guard) begin
            xfer = 1'b1;
            nclk();
            n++;
        end
        xfer = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        int bad;
        int lims[4] = '{1, 2, 3, 5};
        nclk(); nclk();
        // R1: reset state
        chk(!gvalid && !bend, "R1 reset", {gvalid, bend}, 0);
        rdy = 4'b0011;
        rst_n = 1'b1;
        chk(!gvalid && !bend, "R1 first cycle", {gvalid, bend}, 0);

        // R3/R4 sweep: every width, several limits, another port always ready
        for (int w = 0; w < 3; w++) begin
            foreach (lims[j]) begin
                bw = 2'(w);
                lim = 6'(lims[j]);
                wait_grant();
                chk(int'(gport) == next_rr(last, rdy), "R2 alternate", gport, next_rr(last, rdy));
                last = gport;
                run_burst(n, 600);
                chk(n == exp_cap(w, lims[j]), (w == 2 && lims[j] == 1) ? "R4 cap" : "R3 cap",
                    n, exp_cap(w, lims[j]));
                chk(bend && !gvalid, "R9 end pulse", {bend, gvalid}, 2);
            end
        end

        // R5: limit zero removes the cap
        lim = 6'd0; bw = 2'd2;
        wait_grant(); last = gport;
        run_burst(n, 300);
        chk(gvalid && n == 300, "R5 no cap", n, 300);
        xfer = 1'b1; xeop = 1'b1; nclk(); xfer = 1'b0; xeop = 1'b0;
        chk(!gvalid && bend, "R8 eop end", {gvalid, bend}, 1);

        // R6: limit ignored outside packet-level-3 mode
        pl3 = 1'b0; lim = 6'd3;
        wait_grant(); last = gport;
        run_burst(n, 200);
        chk(gvalid && n == 200, "R6 mode ignore", n, 200);
        rdy[gport] = 1'b0; nclk();
        chk(!gvalid && bend, "R8 ready drop", {gvalid, bend}, 1);
        rdy = 4'b0011;

        // R2: round-robin order with wrap over several ready patterns
        begin
            logic [N-1:0] pats[3] = '{4'b1010, 4'b1111, 4'b1001};
            foreach (pats[p]) begin
                rdy = pats[p];
                for (int b = 0; b < 5; b++) begin
                    wait_grant();
                    chk(int'(gport) == next_rr(last, rdy), "R2 round-robin", gport, next_rr(last, rdy));
                    last = gport;
                    xfer = 1'b1; xeop = 1'b1; nclk(); xfer = 1'b0; xeop = 1'b0;
                end
            end
        end

        // R7: lone port stays granted past the cap while above almost-empty
        rdy = 4'b0001; pl3 = 1'b1; bw = 2'd2; lim = 6'd2; ae = 4'b0001;
        wait_grant(); last = gport;
        bad = 0;
        for (int i = 0; i < 9; i++) begin
            xfer = 1'b1; nclk();
            if (!gvalid || bend) bad++;
        end
        xfer = 1'b0;
        chk(bad == 0, "R7 stay above ae", bad, 0);
        ae = '0;
        run_burst(n, 20);
        chk(n == 3 && !gvalid, "R7 release when drained", n, 3);
        ep = 4'b0001;
        wait_grant(); last = gport;
        bad = 0;
        for (int i = 0; i < 7; i++) begin
            xfer = 1'b1; nclk();
            if (!gvalid || bend) bad++;
        end
        xfer = 1'b0;
        chk(bad == 0, "R7 stay eop pending", bad, 0);

        // R8 with R3: end of packet on the capped transfer still ends the burst
        ep = '0; ae = 4'b0001;
        xfer = 1'b1; nclk();
        xeop = 1'b1; nclk();
        xfer = 1'b0; xeop = 1'b0;
        chk(!gvalid && bend, "R8 eop at cap", {gvalid, bend}, 1);
        nclk();
        chk(gvalid && !bend, "R9 single pulse regrant", {gvalid, bend}, 2);
        last = gport;
        xfer = 1'b1; xeop = 1'b1; nclk(); xfer = 1'b0; xeop = 1'b0;
        ae = '0;

        // R10: config change mid-burst leaves the cap alone
        rdy = 4'b0011; bw = 2'd2; lim = 6'd2;
        wait_grant(); last = gport;
        xfer = 1'b1; nclk(); xfer = 1'b0;
        lim = 6'd20; bw = 2'd0;
        run_burst(n, 200);
        chk(n == 2 && !gvalid, "R10 captured cap", n, 2);

        // R11: transfers while idle do not disturb the next count
        rdy = '0; bw = 2'd2; lim = 6'd2;
        for (int i = 0; i < 5; i++) begin
            xfer = 1'b1; nclk();
        end
        xfer = 1'b0;
        chk(!gvalid, "R11 idle", gvalid, 0);
        rdy = 4'b0001;
        wait_grant();
        run_burst(n, 20);
        chk(n == 3, "R11 clean count", n, 3);

        finish_run();
    end
endmodule